// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the chip's interrupt fabric. Each channel raises a single-cycle fire pulse when its comparator logic decides it has expired. The router turns that pulse into a visible interrupt. In level mode it latches a per-channel status bit and holds the chosen interrupt line until software clears the bit by writing one to it. In edge mode it drives a one-cycle pulse on the line. In message mode it drives no line and queues a 32-bit memory write instead.

Every channel has a route field that picks one line out of the array. A global legacy-routing bit overrides the route field for the first two channels: channel 0 is pinned to line 0 and channel 1 to line 8. While legacy routing is off, two external legacy interrupt sources are passed through to those same two lines: an interval-timer source to line 0 and a real-time-clock source to line 8. When legacy routing is on, both sources are masked, and an output tells the interval timer to silence itself. Lines at index 16 and above are active low.

Top module: `tirq_router`

## Requirements
- R1: After reset, every status bit is 0, no message request is valid, lines below index 16 are low and lines at index 16 and above are high.
- R2: A fire on an enabled channel in level mode, with message mode off, sets that channel's status bit (bit c of `sts_o` for channel c) at the next clock edge. The routed line stays asserted for as long as the bit is set.
- R3: A fire on a channel in edge mode clears its status bit and asserts the routed line for exactly the one cycle after the fire edge.
- R4: Outside legacy routing, channel c drives the line whose index is `ch_route_i[c*RW +: RW]`. A route value of `N_LINES` or more drives no line, and several channels on one line are ORed together.
- R5: With `legacy_i` high, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Both external sources are masked and `pit_enable_o` is low. With `legacy_i` low, `pit_enable_o` is high.
- R6: A line at index 16 or higher is driven low when asserted and high when idle. Lower lines are driven high when asserted.
- R7: A status write with bit c of `sts_wdata_i` set clears status bit c at the next edge, unless channel c fires in the same cycle. Bits written as 0 are left unchanged.
- R8: While `glb_en_i` or a channel's enable is low, that channel's line is deasserted at once, its status bit is cleared at the next edge, and its fires are ignored.
- R9: A fire on an enabled channel with message mode on queues a message request and never asserts a line. Turning message mode on deasserts the channel's line at once and clears its status bit at the next edge.
- R10: A queued request appears on `msg_valid_o` one edge after it is queued. The address comes from `ch_msg_addr_i` and the data from `ch_msg_data_i` of that channel, sampled at that edge. The request holds steady until `msg_ready_i` is high at an edge. When several requests are pending, the lowest channel index goes first.
- R11: Outside legacy routing, `ext_pit_i` and `ext_rtc_i` appear on line 0 and line 8 one edge after they are sampled. Their last levels are always recorded, so line 8 shows the latest real-time-clock level as soon as legacy routing is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire_i | input | N_CH | One-cycle fire pulse per channel |
| ch_en_i | input | N_CH | Per-channel interrupt enable |
| ch_level_i | input | N_CH | 1 = level mode, 0 = edge mode |
| ch_msg_en_i | input | N_CH | Per-channel message delivery enable |
| ch_route_i | input | N_CH*RW | Packed line index per channel |
| ch_msg_addr_i | input | N_CH*32 | Message address per channel |
| ch_msg_data_i | input | N_CH*32 | Message data per channel |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy fixed routing |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N_CH | Write-one-to-clear mask |
| sts_o | output | N_CH | Status bits |
| irq_o | output | N_LINES | Interrupt lines |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |
| ext_pit_i | input | 1 | External interval-timer interrupt |
| ext_rtc_i | input | 1 | External real-time-clock interrupt |
| pit_enable_o | output | 1 | Interval-timer output enable |

## Verification
Status bits, edge pulses, message requests and the external-source levels all change one edge after the inputs that cause them. Enables, message mode, route fields and legacy routing act on the lines and on `pit_enable_o` in the same cycle. The bench drives every input at the falling edge and compares all outputs just before the next rising edge against a reference model. That model applies each edge's state changes only after the comparison, so each result is checked in exactly the cycle it is due.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
   localparam int unsigned MSG_W = 32;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tirq_chan.sv
module tirq_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic en_i,
   input  logic level_i,
   input  logic msg_en_i,
   input  logic clr_i,
   output logic sts_o,
   output logic act_o,
   output logic msg_fire_o
);
   logic sts_q;
   logic pulse_q;
   logic live;

   assign live = en_i & ~msg_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (!live)
            sts_q <= 1'b0;
         else if (fire_i)
            sts_q <= level_i;
         else if (clr_i)
            sts_q <= 1'b0;
         pulse_q <= fire_i & live & ~level_i;
      end
   end

   assign sts_o      = sts_q;
   assign act_o      = (sts_q | pulse_q) & live;
   assign msg_fire_o = fire_i & en_i & msg_en_i;
endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb #(
   parameter int unsigned N_CH  = 3,
   parameter int unsigned MW    = 32,
   localparam int unsigned IW   = tirq_pkg::idx_width(N_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CH-1:0]    req_i,
   input  logic [N_CH*MW-1:0] addr_i,
   input  logic [N_CH*MW-1:0] data_i,
   input  logic               ready_i,
   output logic               valid_o,
   output logic [MW-1:0]      addr_o,
   output logic [MW-1:0]      data_o
);
   logic [N_CH-1:0] pend_q;
   logic [N_CH-1:0] grant;
   logic [IW-1:0]   sel;
   logic            found;
   logic            load;
   logic            vld_q;
   logic [MW-1:0]   addr_q;
   logic [MW-1:0]   data_q;

   always_comb begin
      grant = '0;
      sel   = '0;
      found = 1'b0;
      for (int i = 0; i < N_CH; i++) begin
         if (!found && pend_q[i]) begin
            grant[i] = 1'b1;
            sel      = IW'(i);
            found    = 1'b1;
         end
      end
   end

   assign load = found & (~vld_q | ready_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         vld_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         pend_q <= (pend_q & ~(load ? grant : '0)) | req_i;
         if (load) begin
            vld_q  <= 1'b1;
            addr_q <= addr_i[sel*MW +: MW];
            data_q <= data_i[sel*MW +: MW];
         end else if (ready_i) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign valid_o = vld_q;
   assign addr_o  = addr_q;
   assign data_o  = data_q;
endmodule

// File: rtl/tirq_line_map.sv
module tirq_line_map #(
   parameter int unsigned N_CH     = 3,
   parameter int unsigned N_LINES  = 24,
   parameter int unsigned RW       = 5,
   parameter int unsigned INV_BASE = 16,
   parameter int unsigned LINE_A   = 0,
   parameter int unsigned LINE_B   = 8
) (
   input  logic [N_CH-1:0]    act_i,
   input  logic [N_CH*RW-1:0] route_i,
   input  logic               legacy_i,
   input  logic               pit_i,
   input  logic               rtc_i,
   output logic [N_LINES-1:0] irq_o
);
   logic [N_LINES-1:0] hit;

   always_comb begin
      hit = '0;
      for (int c = 0; c < N_CH; c++) begin
         logic [RW:0] dst;
         dst = {1'b0, route_i[c*RW +: RW]};
         if (legacy_i && c == 0) dst = (RW+1)'(LINE_A);
         if (legacy_i && c == 1) dst = (RW+1)'(LINE_B);
         if (act_i[c] && (int'(dst) < N_LINES))
            hit[dst] = 1'b1;
      end
      if (!legacy_i) begin
         hit[LINE_A] = hit[LINE_A] | pit_i;
         hit[LINE_B] = hit[LINE_B] | rtc_i;
      end
   end

   for (genvar l = 0; l < N_LINES; l++) begin : g_pol
      if (l >= INV_BASE) begin : g_low
         assign irq_o[l] = ~hit[l];
      end else begin : g_high
         assign irq_o[l] = hit[l];
      end
   end
endmodule

// File: rtl/tirq_router.sv
module tirq_router #(
   parameter int unsigned N_CH     = 3,
   parameter int unsigned N_LINES  = 24,
   parameter int unsigned INV_BASE = 16,
   parameter int unsigned LINE_A   = 0,
   parameter int unsigned LINE_B   = 8,
   localparam int unsigned RW      = tirq_pkg::idx_width(N_LINES),
   localparam int unsigned MW      = tirq_pkg::MSG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CH-1:0]    fire_i,
   input  logic [N_CH-1:0]    ch_en_i,
   input  logic [N_CH-1:0]    ch_level_i,
   input  logic [N_CH-1:0]    ch_msg_en_i,
   input  logic [N_CH*RW-1:0] ch_route_i,
   input  logic [N_CH*MW-1:0] ch_msg_addr_i,
   input  logic [N_CH*MW-1:0] ch_msg_data_i,
   input  logic               glb_en_i,
   input  logic               legacy_i,
   input  logic               sts_wr_i,
   input  logic [N_CH-1:0]    sts_wdata_i,
   output logic [N_CH-1:0]    sts_o,
   output logic [N_LINES-1:0] irq_o,
   output logic               msg_valid_o,
   input  logic               msg_ready_i,
   output logic [MW-1:0]      msg_addr_o,
   output logic [MW-1:0]      msg_data_o,
   input  logic               ext_pit_i,
   input  logic               ext_rtc_i,
   output logic               pit_enable_o
);
   if (N_CH < 2 || LINE_A >= N_LINES || LINE_B >= N_LINES || LINE_A == LINE_B)
   begin : g_bad_cfg
      $error("tirq_router: needs two channels and two distinct legacy lines in range");
   end

   logic [N_CH-1:0] act;
   logic [N_CH-1:0] msg_fire;
   logic            pit_q;
   logic            rtc_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tirq_chan u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .fire_i     (fire_i[c]),
         .en_i       (glb_en_i & ch_en_i[c]),
         .level_i    (ch_level_i[c]),
         .msg_en_i   (ch_msg_en_i[c]),
         .clr_i      (sts_wr_i & sts_wdata_i[c]),
         .sts_o      (sts_o[c]),
         .act_o      (act[c]),
         .msg_fire_o (msg_fire[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pit_q <= 1'b0;
         rtc_q <= 1'b0;
      end else begin
         pit_q <= ext_pit_i;
         rtc_q <= ext_rtc_i;
      end
   end

   tirq_line_map #(
      .N_CH(N_CH), .N_LINES(N_LINES), .RW(RW),
      .INV_BASE(INV_BASE), .LINE_A(LINE_A), .LINE_B(LINE_B)
   ) u_map (
      .act_i    (act),
      .route_i  (ch_route_i),
      .legacy_i (legacy_i),
      .pit_i    (pit_q),
      .rtc_i    (rtc_q),
      .irq_o    (irq_o)
   );

   tirq_msg_arb #(.N_CH(N_CH), .MW(MW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (msg_fire),
      .addr_i  (ch_msg_addr_i),
      .data_i  (ch_msg_data_i),
      .ready_i (msg_ready_i),
      .valid_o (msg_valid_o),
      .addr_o  (msg_addr_o),
      .data_o  (msg_data_o)
   );

   assign pit_enable_o = ~legacy_i;
endmodule

// File: rtl/tirq_router_chk.sv
module tirq_router_chk #(
   parameter int unsigned N_CH = 3,
   parameter int unsigned MW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] fire_i,
   input logic [N_CH-1:0] ch_en_i,
   input logic [N_CH-1:0] ch_level_i,
   input logic [N_CH-1:0] ch_msg_en_i,
   input logic            glb_en_i,
   input logic            sts_wr_i,
   input logic [N_CH-1:0] sts_wdata_i,
   input logic [N_CH-1:0] sts_o,
   input logic            msg_valid_o,
   input logic            msg_ready_i,
   input logic [MW-1:0]   msg_addr_o,
   input logic [MW-1:0]   msg_data_o
);
   for (genvar c = 0; c < N_CH; c++) begin : g_c
      // R2
      level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (glb_en_i && ch_en_i[c] && ch_level_i[c] && !ch_msg_en_i[c] && fire_i[c]) |=> sts_o[c]);
      // R3
      edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fire_i[c] && !ch_level_i[c]) |=> !sts_o[c]);
      // R7
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_wr_i && sts_wdata_i[c] && !fire_i[c]) |=> !sts_o[c]);
      // R8
      off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!glb_en_i || !ch_en_i[c]) |=> !sts_o[c]);
      // R9
      msg_nosts_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_msg_en_i[c] |=> !sts_o[c]);
   end

   // R10
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i) |=>
         (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
endmodule

bind tirq_router tirq_router_chk #(.N_CH(N_CH), .MW(MW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fire_i      (fire_i),
   .ch_en_i     (ch_en_i),
   .ch_level_i  (ch_level_i),
   .ch_msg_en_i (ch_msg_en_i),
   .glb_en_i    (glb_en_i),
   .sts_wr_i    (sts_wr_i),
   .sts_wdata_i (sts_wdata_i),
   .sts_o       (sts_o),
   .msg_valid_o (msg_valid_o),
   .msg_ready_i (msg_ready_i),
   .msg_addr_o  (msg_addr_o),
   .msg_data_o  (msg_data_o)
);

// File: tb/tirq_router_bench.sv
module tirq_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 3;
   localparam int NL = 24;
   localparam int RW = 5;
   localparam int MW = 32;

   logic clk = 0;
   logic rst_n = 0;
   logic [NC-1:0] fire = '0, en = '0, level = '0, msg_en = '0, wdata = '0;
   logic [NC*RW-1:0] route = '0;
   logic [NC*MW-1:0] maddr = '0, mdata = '0;
   logic glb = 0, legacy = 0, wr = 0, ready = 0, pit = 0, rtc = 0;
   logic [NC-1:0] sts;
   logic [NL-1:0] irq;
   logic mvld, pit_en;
   logic [MW-1:0] aout, dout;

   // reference model state
   logic [NC-1:0] m_sts = '0, m_pulse = '0, m_pend = '0;
   logic m_vld = 0, m_pit = 0, m_rtc = 0;
   logic [MW-1:0] m_addr = '0, m_data = '0;

   int total = 0, bad = 0;
   bit done = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   tirq_router u_tirq_router (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .ch_en_i(en), .ch_level_i(level),
      .ch_msg_en_i(msg_en), .ch_route_i(route), .ch_msg_addr_i(maddr),
      .ch_msg_data_i(mdata), .glb_en_i(glb), .legacy_i(legacy), .sts_wr_i(wr),
      .sts_wdata_i(wdata), .sts_o(sts), .irq_o(irq), .msg_valid_o(mvld),
      .msg_ready_i(ready), .msg_addr_o(aout), .msg_data_o(dout),
      .ext_pit_i(pit), .ext_rtc_i(rtc), .pit_enable_o(pit_en)
   );

   function automatic logic [NL-1:0] exp_irq();
      logic [NL-1:0] h = '0;
      for (int c = 0; c < NC; c++) begin
         int ln = int'(route[c*RW +: RW]);
         logic live = glb & en[c] & ~msg_en[c];
         if (legacy && c == 0) ln = 0;
         if (legacy && c == 1) ln = 8;
         if ((m_sts[c] | m_pulse[c]) && live && ln < NL) h[ln] = 1'b1;
      end
      if (!legacy) begin
         h[0] = h[0] | m_pit;
         h[8] = h[8] | m_rtc;
      end
      for (int l = 16; l < NL; l++) h[l] = ~h[l];
      return h;
   endfunction

   task automatic chk(input string t, input string what, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%h exp=%h at %0t", t, what, got, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic [NC-1:0] n_sts, n_pulse, grant;
      logic found = 0;
      int s = 0;
      for (int c = 0; c < NC; c++) begin
         logic live = glb & en[c] & ~msg_en[c];
         if (!live) n_sts[c] = 0;
         else if (fire[c]) n_sts[c] = level[c];
         else if (wr && wdata[c]) n_sts[c] = 0;
         else n_sts[c] = m_sts[c];
         n_pulse[c] = fire[c] & live & ~level[c];
      end
      grant = '0;
      for (int c = 0; c < NC; c++)
         if (!found && m_pend[c]) begin found = 1; grant[c] = 1; s = c; end
      if (found && (!m_vld || ready)) begin
         m_vld = 1; m_addr = maddr[s*MW +: MW]; m_data = mdata[s*MW +: MW];
      end else begin
         grant = '0;
         if (ready) m_vld = 0;
      end
      m_pend = (m_pend & ~grant) | (fire & en & msg_en & {NC{glb}});
      m_sts = n_sts; m_pulse = n_pulse; m_pit = pit; m_rtc = rtc;
   endtask

   task automatic step();
      #1;
      chk(tag, "irq", 64'(irq), 64'(exp_irq()));
      chk(tag, "sts", 64'(sts), 64'(m_sts));
      chk(tag, "msg_valid", 64'(mvld), 64'(m_vld));
      if (m_vld) begin
         chk(tag, "msg_addr", 64'(aout), 64'(m_addr));
         chk(tag, "msg_data", 64'(dout), 64'(m_data));
      end
      chk(tag, "pit_enable", 64'(pit_en), 64'(!legacy));
      @(posedge clk);
      model_edge();
      @(negedge clk);
      fire = '0; wr = 0;
   endtask

   task automatic set_route(input int c, input int v);
      route[c*RW +: RW] = RW'(v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int c = 0; c < NC; c++) begin
         maddr[c*MW +: MW] = 32'hF000_0000 + 32'(c * 16);
         mdata[c*MW +: MW] = 32'hA5A5_0000 + 32'(c);
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      tag = "R1";
      chk("R1", "irq_reset", 64'(irq), 64'(24'hFF0000));
      step();

      // R2 level fire on channel 0 to line 3
      tag = "R2"; glb = 1; en = 3'b111; level = 3'b101;
      set_route(0, 3); set_route(1, 5); set_route(2, 27);
      fire = 3'b001; step(); step();
      chk("R2", "line3_high", 64'(irq[3]), 64'd1);

      // R3 edge fire on channel 1 to line 5
      tag = "R3"; fire = 3'b010; step();
      chk("R3", "pulse_on", 64'(irq[5]), 64'd1);
      step();
      chk("R3", "pulse_off", 64'(irq[5]), 64'd0);

      // R4 out-of-range route drives nothing
      tag = "R4"; fire = 3'b100; step(); step();
      chk("R4", "no_line", 64'(irq), 64'(24'hFF0008));

      // R6 active-low line
      tag = "R6"; set_route(2, 18); step();
      chk("R6", "line18_low", 64'(irq[18]), 64'd0);

      // R7 write one to clear only channel 0
      tag = "R7"; wr = 1; wdata = 3'b001; step(); step();
      chk("R7", "sts_after_w1c", 64'(sts), 64'(3'b100));

      // R8 global disable
      tag = "R8"; glb = 0; step();
      chk("R8", "line18_idle", 64'(irq[18]), 64'd1);
      step(); glb = 1; step();

      // R9 message mode
      tag = "R9"; msg_en = 3'b101; fire = 3'b101; step(); step();
      chk("R9", "no_lines", 64'(irq), 64'(24'hFF0000));
      // R10 hold then ordered drain
      tag = "R10";
      repeat (3) step();
      chk("R10", "first_ch0", 64'(aout), 64'(32'hF000_0000));
      ready = 1; step(); step(); step();
      ready = 0; msg_en = '0;

      // R5 legacy routing
      tag = "R5"; legacy = 1; pit = 1; rtc = 1; level = 3'b111;
      set_route(0, 12); set_route(1, 13);
      fire = 3'b011; step(); step();
      chk("R5", "legacy_lines", 64'({irq[8], irq[0], irq[12]}), 64'(3'b110));
      wr = 1; wdata = 3'b011; step();

      // R11 leaving legacy restores recorded levels
      tag = "R11"; step(); legacy = 0; step();
      chk("R11", "rtc_restored", 64'(irq[8]), 64'd1);
      pit = 0; rtc = 0; step(); step();

      // random phase
      tag = "R4";
      for (int i = 0; i < 4000; i++) begin
         fire   = NC'($urandom) & NC'($urandom);
         en     = NC'($urandom) | NC'($urandom);
         level  = NC'($urandom);
         msg_en = NC'($urandom) & NC'($urandom);
         glb    = ($urandom % 8) != 0;
         legacy = ($urandom % 6) == 0;
         wr     = ($urandom % 5) == 0;
         wdata  = NC'($urandom);
         ready  = $urandom % 2;
         pit    = $urandom % 2;
         rtc    = $urandom % 2;
         for (int c = 0; c < NC; c++) set_route(c, int'($urandom % 32));
         if (i % 97 == 0) maddr[(i % NC)*MW +: MW] = $urandom;
         step();
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule